// File: doc/BRIEF.md
# Threshold or Data-Ready Alert Generator

This block decides when a monitor's alert pin should be pulled low. The pin is open drain. The block drives only a pull-low enable, and the pad releases the line to high impedance whenever the enable is 0. A single mode input picks one of two behaviours.

In data-ready mode the enable rises once a new measurement result has been loaded. It falls again after the bus logic reports that the result register has been read.

In threshold mode the enable follows a level comparison. The comparison runs between the current 16-bit result word and a 7-bit threshold, and it applies whatever quantity the result represents.

The result word is a signed count. The sign is in bit 15 and the integer count occupies bits 15:6, with six fraction bits below it. The threshold has coarser resolution: it drops the two lowest count bits and is compared against count bits 8:2, which are word bits 14:8. All inputs are plain control and status levels or single-cycle pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The enable is registered and responds one clock after its inputs.

Top module: `alert_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pull_low` is 0, and the internal pending state and the remembered mode are cleared (the remembered mode resets to data-ready).
- R2: With `mode_level` = 0 (data-ready mode), a `new_data` pulse sets `pull_low` to 1 from the next clock edge. It stays 1 until a read is reported.
- R3: In data-ready mode, a `read_done` pulse without `new_data` clears `pull_low` at the next clock edge. A read with nothing pending leaves it at 0.
- R4: In data-ready mode, `new_data` and `read_done` in the same cycle leave `pull_low` at 1 after the edge.
- R5: In any cycle where `mode_level` differs from its value in the previous cycle, the pending data-ready state is cleared. A `new_data` pulse in that same cycle is discarded, so switching into data-ready mode gives `pull_low` = 0 until the next `new_data`.
- R6: With `mode_level` = 1 (threshold mode), `pull_low` one edge later equals 1 exactly when `result[15]` = 0 and the unsigned value `result[14:8]` is strictly greater than `threshold`.
- R7: In threshold mode a negative result (`result[15]` = 1) never asserts `pull_low`. A field equal to the threshold does not assert it, and a threshold of 127 never asserts it.
- R8: In threshold mode, `new_data` and `read_done` have no effect on `pull_low`.
- R9: In data-ready mode the value of `result` and `threshold` has no effect on `pull_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_level | input | 1 | 0 = data-ready alert, 1 = threshold alert (reset default of the configuration is 0) |
| threshold | input | 7 | Threshold compared against result bits 14:8 |
| result | input | 16 | Current result word, sign in bit 15, six fraction bits |
| new_data | input | 1 | One-cycle pulse: a new result has been loaded |
| read_done | input | 1 | One-cycle pulse: the result register was read over the bus |
| pull_low | output | 1 | 1 = pull the alert pin low, 0 = release it |

## Verification
Every response of this block is due exactly one clock edge after the inputs that cause it. This holds for setting, clearing, the same-cycle collision, a mode switch and a threshold crossing. The bench drives inputs on the falling edge. Its behavioural model takes those inputs at the rising edge and produces the enable expected after that edge, and the bench compares that value with `pull_low` at the following falling edge, on every cycle. The stimulus passes through phases tagged with the requirement they exercise, including the equal and maximum thresholds, negative results and pulses issued in the wrong mode.

// File: rtl/alert_pkg.sv
package alert_pkg;
  typedef enum logic {
    ALERT_ON_READY = 1'b0,
    ALERT_ON_LEVEL = 1'b1
  } alert_mode_e;

  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned FRAC_W_DEF = 6;
  localparam int unsigned DROP_W_DEF = 2;
  localparam int unsigned THR_W_DEF  = 7;
endpackage

// File: rtl/alert_ready_track.sv
module alert_ready_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_chg,
  input  logic new_data,
  input  logic read_done,
  output logic pend_next,
  output logic pend
);
  // Priority: a mode switch wipes the state, a new result beats a read.
  always_comb begin
    if (mode_chg)       pend_next = 1'b0;
    else if (new_data)  pend_next = 1'b1;
    else if (read_done) pend_next = 1'b0;
    else                pend_next = pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_next;
  end
endmodule

// File: rtl/alert_level_cmp.sv
module alert_level_cmp #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned FRAC_W    = 6,
  parameter int unsigned DROP_W    = 2,
  parameter int unsigned THR_W     = 7,
  parameter bit          SIGN_GATE = 1'b1
) (
  input  logic [WORD_W-1:0] result,
  input  logic [THR_W-1:0]  threshold,
  output logic              exceed
);
  localparam int unsigned LO = FRAC_W + DROP_W;
  localparam int unsigned HI = LO + THR_W - 1;

  logic [THR_W-1:0] field;
  logic             above;

  assign field = result[HI:LO];
  assign above = (field > threshold);

  generate
    if (SIGN_GATE) begin : g_signed
      assign exceed = above & ~result[WORD_W-1];
    end else begin : g_unsigned
      assign exceed = above;
    end
  endgenerate
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import alert_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned DROP_W = DROP_W_DEF,
  parameter int unsigned THR_W  = THR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_level,
  input  logic [THR_W-1:0]  threshold,
  input  logic [WORD_W-1:0] result,
  input  logic              new_data,
  input  logic              read_done,
  output logic              pull_low
);
  alert_mode_e mode_now, mode_q;
  logic        mode_chg;
  logic        pend_next, pend;
  logic        exceed;
  logic        drive_q;

  assign mode_now = alert_mode_e'(mode_level);
  assign mode_chg = (mode_now != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ALERT_ON_READY;
    else        mode_q <= mode_now;
  end

  alert_ready_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_chg  (mode_chg),
    .new_data  (new_data),
    .read_done (read_done),
    .pend_next (pend_next),
    .pend      (pend)
  );

  alert_level_cmp #(
    .WORD_W    (WORD_W),
    .FRAC_W    (FRAC_W),
    .DROP_W    (DROP_W),
    .THR_W     (THR_W),
    .SIGN_GATE (1'b1)
  ) u_cmp (
    .result    (result),
    .threshold (threshold),
    .exceed    (exceed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                        drive_q <= 1'b0;
    else if (mode_now == ALERT_ON_LEVEL) drive_q <= exceed;
    else                               drive_q <= pend_next;
  end

  assign pull_low = drive_q;
endmodule

// File: rtl/alert_ctrl_chk.sv
module alert_ctrl_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned THR_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_level,
  input logic [THR_W-1:0]  threshold,
  input logic [WORD_W-1:0] result,
  input logic              new_data,
  input logic              read_done,
  input logic              pull_low
);
  logic mode_prev;
  logic steady_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_prev <= 1'b0;
    else        mode_prev <= mode_level;
  end

  assign steady_ready = !mode_level && !mode_prev;

  // R1: output low in the cycle after reset is applied
  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !pull_low);

  // R2
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    steady_ready && new_data |=> pull_low);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    steady_ready && pull_low && !read_done |=> pull_low);

  // R3
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    steady_ready && read_done && !new_data |=> !pull_low);

  // R5
  assert_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_level && mode_prev |=> !pull_low);

  // R7
  assert_negative_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_level && result[WORD_W-1] |=> !pull_low);
  assert_max_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_level && (threshold == {THR_W{1'b1}}) |=> !pull_low);
endmodule

bind alert_ctrl alert_ctrl_chk #(.WORD_W(WORD_W), .THR_W(THR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_level (mode_level),
  .threshold  (threshold),
  .result     (result),
  .new_data   (new_data),
  .read_done  (read_done),
  .pull_low   (pull_low)
);

// File: tb/alert_ctrl_test.sv
`timescale 1ns/1ps
module alert_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_level = 1'b0;
  logic [6:0]  threshold = '0;
  logic [15:0] result = '0;
  logic        new_data = 1'b0;
  logic        read_done = 1'b0;
  logic        pull_low;

  int    compared = 0;
  int    mismatched = 0;
  string phase = "R1 reset";
  bit    finished = 1'b0;

  // Reference model state.
  int exp_out = 0;
  int exp_pend = 0;
  int exp_mprev = 0;

  always #2 clk = ~clk;

  alert_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_level(mode_level), .threshold(threshold),
    .result(result), .new_data(new_data), .read_done(read_done), .pull_low(pull_low)
  );

  function automatic int level_hit(logic [15:0] w, logic [6:0] t);
    int fld;
    if (w[15]) return 0;
    fld = (int'(w) / 256) % 128;
    return (fld > int'(t)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_out = 0; exp_pend = 0; exp_mprev = 0;
    end else begin
      if (int'(mode_level) != exp_mprev) exp_pend = 0;
      else if (new_data)                 exp_pend = 1;
      else if (read_done)                exp_pend = 0;
      exp_out   = mode_level ? level_hit(result, threshold) : exp_pend;
      exp_mprev = int'(mode_level);
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (int'(pull_low) != exp_out) begin
        mismatched++;
        $display("FAIL %s: pull_low actual %0d expected %0d at %0t", phase, pull_low, exp_out, $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_new();
    new_data = 1'b1; step(1); new_data = 1'b0;
  endtask

  task automatic pulse_read();
    read_done = 1'b1; step(1); read_done = 1'b0;
  endtask

  function automatic logic [15:0] cnt_word(int c);
    return 16'(c * 64);
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    phase = "R1 reset";
    step(3);
    rst_n = 1'b1;
    step(2);

    phase = "R2 set and hold";
    pulse_new(); step(4);
    phase = "R9 result ignored in ready mode";
    result = cnt_word(300); threshold = 7'd1; step(3);
    phase = "R3 read clears";
    pulse_read(); step(3);
    phase = "R3 read with nothing pending";
    pulse_read(); step(2);
    phase = "R4 simultaneous new and read";
    new_data = 1'b1; read_done = 1'b1; step(1);
    new_data = 1'b0; read_done = 1'b0; step(3);
    pulse_read(); step(2);
    phase = "R9 ready mode, no pulse, large result";
    result = cnt_word(511); threshold = 7'd0; step(3);

    phase = "R5 switch to threshold with pending set";
    pulse_new(); step(1);
    result = cnt_word(0); threshold = 7'd10;
    mode_level = 1'b1; step(3);

    phase = "R6 field equal to threshold";
    result = cnt_word(43); step(2);
    phase = "R6 field above threshold";
    result = cnt_word(44); step(2);
    result = cnt_word(40); step(2);
    phase = "R6 top field";
    threshold = 7'd126; result = cnt_word(511); step(2);
    phase = "R7 max threshold";
    threshold = 7'd127; step(2);
    phase = "R7 negative result";
    threshold = 7'd0; result = cnt_word(-256); step(2);
    result = 16'hFFFF; step(2);
    phase = "R6 zero threshold, field zero and one";
    result = cnt_word(3); step(2);
    result = cnt_word(4); step(2);
    phase = "R8 pulses in threshold mode, above";
    pulse_read(); step(1); pulse_new(); step(1);
    phase = "R8 pulses in threshold mode, below";
    result = cnt_word(2); step(1);
    pulse_new(); step(1); pulse_read(); step(1);

    phase = "R5 switch back with new data clears";
    pulse_new();
    mode_level = 1'b0; new_data = 1'b1; step(1); new_data = 1'b0; step(3);
    phase = "R2 set after switch";
    pulse_new(); step(2);
    phase = "R5 switch back and forth";
    mode_level = 1'b1; result = cnt_word(0); step(2);
    mode_level = 1'b0; step(3);
    phase = "R1 reset mid-alert";
    pulse_new(); step(1);
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule